// File: doc/BRIEF.md
# Conditional binding trail unit

This block keeps the undo record for variable bindings made by a logic-programming engine. Whenever the engine binds a variable it presents the variable's word address together with one bit saying whether the variable sits in the control stack or in the heap. The unit compares that address with the matching backtrack mark. The choice-point base is used for stack variables and the heap backtrack mark for heap variables. The address is recorded only when it lies below the mark, because a younger variable is discarded on backtracking anyway. Records are pushed onto a trail that grows toward lower addresses from a configured top. Each push takes one word and moves the trail pointer down by one.

When a goal fails, the engine hands over the trail pointer saved in the newest choice point. The unit then walks the trail from its current top back up to that saved value, newest entry first. For each entry it reads the recorded address and overwrites that variable with an unbound word. An unbound word holds the variable tag in its top byte and its own address in the address field. When the walk is complete the unit raises a one-cycle done pulse, and the trail pointer then equals the saved value. If a push would go below the configured trail floor, it is dropped and a sticky overflow flag is set. All memory traffic uses one synchronous single-port word interface with a read latency of one cycle.

Top module: `trail_unit`

## Requirements
- R1: After reset, `tr` equals TRAIL_TOP, `ovf` and `fail_done` are 0, `bind_ready` is 1 and `mem_en` is 0.
- R2: A bind with `bind_in_heap`=0 and `bind_addr` < `mark_b` is trailed. In the same cycle as the handshake, the unit writes the zero-extended address to memory word `tr`, and `tr` is one lower after that clock edge.
- R3: The select bit picks the mark: `bind_in_heap`=1 compares against `mark_hb` only, and `bind_in_heap`=0 compares against `mark_b` only. A heap bind below `mark_hb` is trailed exactly like R2.
- R4: A bind whose address is equal to or above its mark completes in its handshake cycle with no memory write and no change to `tr`.
- R5: A trailed bind arriving while `tr` < TRAIL_FLOOR is dropped, with no write and no change to `tr`, and sets `ovf`. `ovf` stays set until reset, so the trail holds TRAIL_TOP-TRAIL_FLOOR+1 entries.
- R6: During an unwind, each entry is read from address `tr`+1 and its data returns one cycle later. The unit then writes to the recorded address the word {VAR_TAG, zeros, address}, with the tag in bits 31:24 and the address in the low ADDR_W bits.
- R7: Unwinding restores entries newest first, which means from the lowest trail address upward.
- R8: For a saved value `fail_tr` that is N entries above `tr`, `fail_done` pulses for one cycle 2N clock edges after the accepting edge, and `tr` then equals `fail_tr`. If `fail_tr` <= `tr`, the pulse follows at once, with no memory access and `tr` unchanged.
- R9: `bind_ready` is low while an unwind is in progress and whenever `fail_valid` is high. A simultaneous bind request therefore waits and does not touch the trail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bind_valid | input | 1 | Bind request present |
| bind_ready | output | 1 | Bind request accepted this cycle when valid |
| bind_addr | input | ADDR_W | Word address of the variable just bound |
| bind_in_heap | input | 1 | 1: variable in heap, 0: variable in control stack |
| mark_b | input | ADDR_W | Current choice-point base |
| mark_hb | input | ADDR_W | Heap top at the time of the newest choice point |
| fail_valid | input | 1 | Start an unwind (taken when the unit is idle) |
| fail_tr | input | ADDR_W | Trail pointer saved in the choice point |
| fail_done | output | 1 | One-cycle pulse: unwind finished |
| tr | output | ADDR_W | Current trail pointer (next free slot) |
| ovf | output | 1 | Sticky trail overflow flag |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |

## Verification
A trail push shows up on the memory port in the same cycle as the handshake, so the bench samples `mem_we` and `mem_addr` just before that clock edge. It then reads the pointer and its memory model just after the edge. The overflow flag and the decremented pointer are both due one edge after the request. For an unwind of N entries the bench counts clock edges from the accepting edge and expects `fail_done` after exactly 2N of them. Two edges per entry cover the read, the one-cycle read latency and the write. A write log kept in the memory model lets the bench compare the order and the content of the restoring writes.

// File: rtl/trail_pkg.sv
package trail_pkg;

   typedef enum logic [1:0] {
      UW_IDLE  = 2'd0,
      UW_READ  = 2'd1,
      UW_WRITE = 2'd2,
      UW_DONE  = 2'd3
   } unw_state_e;

endpackage

// File: rtl/trail_age_filter.sv
module trail_age_filter #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] var_addr,
   input  logic              in_heap,
   input  logic [ADDR_W-1:0] stack_mark,
   input  logic [ADDR_W-1:0] heap_mark,
   output logic              is_old
);
   logic [ADDR_W-1:0] sel_mark;

   always_comb begin
      sel_mark = in_heap ? heap_mark : stack_mark;
      is_old   = (var_addr < sel_mark);
   end
endmodule

// File: rtl/trail_ptr.sv
module trail_ptr #(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] TRAIL_TOP   = '1,
   parameter logic [ADDR_W-1:0] TRAIL_FLOOR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop,
   output logic              room,
   output logic [ADDR_W-1:0] tr_q,
   output logic              ovf_q
);
   always_comb room = (tr_q >= TRAIL_FLOOR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tr_q  <= TRAIL_TOP;
         ovf_q <= 1'b0;
      end else begin
         if (push_req && room)
            tr_q <= tr_q - 1'b1;
         else if (pop)
            tr_q <= tr_q + 1'b1;
         if (push_req && !room)
            ovf_q <= 1'b1;
      end
   end
endmodule

// File: rtl/trail_unwind.sv
module trail_unwind
   import trail_pkg::*;
#(
   parameter int               ADDR_W  = 16,
   parameter int               DATA_W  = 32,
   parameter int               TAG_W   = 8,
   parameter logic [TAG_W-1:0] VAR_TAG = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] saved_tr,
   input  logic [ADDR_W-1:0] tr,
   input  logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic              done,
   output logic              pop,
   output logic              rd_en,
   output logic              wr_en,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);
   localparam int PAD_W = DATA_W - TAG_W - ADDR_W;

   unw_state_e        state_q, state_d;
   logic [ADDR_W-1:0] saved_q;
   logic [ADDR_W-1:0] tr_next;
   logic [ADDR_W-1:0] var_addr;
   logic [DATA_W-1:0] unbound_word;

   assign tr_next  = tr + 1'b1;
   assign var_addr = rdata[ADDR_W-1:0];

   generate
      if (PAD_W > 0) begin : g_pad
         assign unbound_word = {VAR_TAG, {PAD_W{1'b0}}, var_addr};
      end else begin : g_nopad
         assign unbound_word = {VAR_TAG, var_addr};
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      rd_en   = 1'b0;
      wr_en   = 1'b0;
      pop     = 1'b0;
      done    = 1'b0;
      addr    = tr_next;
      wdata   = unbound_word;
      unique case (state_q)
         UW_IDLE: begin
            if (start)
               state_d = (saved_tr > tr) ? UW_READ : UW_DONE;
         end
         UW_READ: begin
            rd_en   = 1'b1;
            state_d = UW_WRITE;
         end
         UW_WRITE: begin
            wr_en   = 1'b1;
            pop     = 1'b1;
            addr    = var_addr;
            state_d = (tr_next == saved_q) ? UW_DONE : UW_READ;
         end
         UW_DONE: begin
            done    = 1'b1;
            state_d = UW_IDLE;
         end
         default: state_d = UW_IDLE;
      endcase
   end

   assign busy = (state_q != UW_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= UW_IDLE;
         saved_q <= '0;
      end else begin
         state_q <= state_d;
         if (start && state_q == UW_IDLE)
            saved_q <= saved_tr;
      end
   end
endmodule

// File: rtl/trail_unit.sv
module trail_unit #(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 32,
   parameter int                TAG_W       = 8,
   parameter logic [TAG_W-1:0]  VAR_TAG     = 8'hA0,
   parameter logic [ADDR_W-1:0] TRAIL_TOP   = '1,
   parameter logic [ADDR_W-1:0] TRAIL_FLOOR = {2'b11, {(ADDR_W-2){1'b0}}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bind_valid,
   output logic              bind_ready,
   input  logic [ADDR_W-1:0] bind_addr,
   input  logic              bind_in_heap,
   input  logic [ADDR_W-1:0] mark_b,
   input  logic [ADDR_W-1:0] mark_hb,
   input  logic              fail_valid,
   input  logic [ADDR_W-1:0] fail_tr,
   output logic              fail_done,
   output logic [ADDR_W-1:0] tr,
   output logic              ovf,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int EXT_W = DATA_W - ADDR_W;

   initial begin
      if (ADDR_W + TAG_W > DATA_W)
         $error("trail_unit: address field and tag do not fit in a data word");
      if (TRAIL_FLOOR == '0)
         $error("trail_unit: trail floor must be above address zero");
      if (TRAIL_TOP < TRAIL_FLOOR)
         $error("trail_unit: trail top lies below trail floor");
   end

   logic              is_old;
   logic              room;
   logic              bind_fire;
   logic              push_req;
   logic              push_do;
   logic              unw_busy;
   logic              unw_pop;
   logic              unw_rd;
   logic              unw_wr;
   logic [ADDR_W-1:0] unw_addr;
   logic [DATA_W-1:0] unw_wdata;
   logic              unw_start;

   assign bind_ready = !unw_busy && !fail_valid;
   assign bind_fire  = bind_valid && bind_ready;
   assign push_req   = bind_fire && is_old;
   assign push_do    = push_req && room;
   assign unw_start  = fail_valid && !unw_busy;

   trail_age_filter #(.ADDR_W(ADDR_W)) u_age (
      .var_addr   (bind_addr),
      .in_heap    (bind_in_heap),
      .stack_mark (mark_b),
      .heap_mark  (mark_hb),
      .is_old     (is_old)
   );

   trail_ptr #(
      .ADDR_W      (ADDR_W),
      .TRAIL_TOP   (TRAIL_TOP),
      .TRAIL_FLOOR (TRAIL_FLOOR)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (push_req),
      .pop      (unw_pop),
      .room     (room),
      .tr_q     (tr),
      .ovf_q    (ovf)
   );

   trail_unwind #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .TAG_W   (TAG_W),
      .VAR_TAG (VAR_TAG)
   ) u_unw (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (unw_start),
      .saved_tr (fail_tr),
      .tr       (tr),
      .rdata    (mem_rdata),
      .busy     (unw_busy),
      .done     (fail_done),
      .pop      (unw_pop),
      .rd_en    (unw_rd),
      .wr_en    (unw_wr),
      .addr     (unw_addr),
      .wdata    (unw_wdata)
   );

   always_comb begin
      if (unw_busy) begin
         mem_en    = unw_rd || unw_wr;
         mem_we    = unw_wr;
         mem_addr  = unw_addr;
         mem_wdata = unw_wdata;
      end else begin
         mem_en    = push_do;
         mem_we    = push_do;
         mem_addr  = tr;
         mem_wdata = {{EXT_W{1'b0}}, bind_addr};
      end
   end
endmodule

// File: rtl/trail_unit_chk.sv
module trail_unit_chk #(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 32,
   parameter int                TAG_W       = 8,
   parameter logic [TAG_W-1:0]  VAR_TAG     = 8'hA0,
   parameter logic [ADDR_W-1:0] TRAIL_FLOOR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bind_valid,
   input logic              bind_ready,
   input logic [ADDR_W-1:0] bind_addr,
   input logic              bind_in_heap,
   input logic [ADDR_W-1:0] mark_b,
   input logic [ADDR_W-1:0] mark_hb,
   input logic              fail_valid,
   input logic [ADDR_W-1:0] fail_tr,
   input logic              fail_done,
   input logic [ADDR_W-1:0] tr,
   input logic              ovf,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              unw_busy
);
   logic              fire;
   logic [ADDR_W-1:0] saved_q;

   assign fire = bind_valid && bind_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         saved_q <= '0;
      else if (fail_valid && !unw_busy)
         saved_q <= fail_tr;
   end

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mem_we) |=> (tr == $past(tr) - 1'b1)); // R2

   AST_PUSH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mem_we) |-> (mem_addr == tr && mem_wdata[ADDR_W-1:0] == bind_addr)); // R2

   AST_STACK_YOUNG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !bind_in_heap && bind_addr >= mark_b) |-> !mem_we); // R4

   AST_HEAP_YOUNG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && bind_in_heap && bind_addr >= mark_hb) |-> !mem_we); // R3

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mem_we) |-> (tr >= TRAIL_FLOOR)); // R5

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf); // R5

   AST_UNBOUND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (unw_busy && mem_we) |->
         (mem_wdata[DATA_W-1 -: TAG_W] == VAR_TAG && mem_wdata[ADDR_W-1:0] == mem_addr)); // R6

   AST_DONE_AT_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
      fail_done |-> (tr == saved_q)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fail_done |=> !fail_done); // R8

   AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (unw_busy || fail_valid) |-> !bind_ready); // R9
endmodule

bind trail_unit trail_unit_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .TAG_W       (TAG_W),
   .VAR_TAG     (VAR_TAG),
   .TRAIL_FLOOR (TRAIL_FLOOR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bind_valid   (bind_valid),
   .bind_ready   (bind_ready),
   .bind_addr    (bind_addr),
   .bind_in_heap (bind_in_heap),
   .mark_b       (mark_b),
   .mark_hb      (mark_hb),
   .fail_valid   (fail_valid),
   .fail_tr      (fail_tr),
   .fail_done    (fail_done),
   .tr           (tr),
   .ovf          (ovf),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .mem_wdata    (mem_wdata),
   .unw_busy     (unw_busy)
);

// File: tb/trail_unit_tb.sv
`timescale 1ns/1ps
module trail_unit_tb;
   localparam int          AW    = 10;
   localparam int          DW    = 32;
   localparam logic [7:0]  TAG   = 8'hA0;
   localparam logic [AW-1:0] TOP = 10'h3FF;
   localparam logic [AW-1:0] FLR = 10'h3F8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bind_valid = 1'b0;
   logic          bind_ready;
   logic [AW-1:0] bind_addr = '0;
   logic          bind_in_heap = 1'b0;
   logic [AW-1:0] mark_b = 10'h100;
   logic [AW-1:0] mark_hb = 10'h200;
   logic          fail_valid = 1'b0;
   logic [AW-1:0] fail_tr = '0;
   logic          fail_done;
   logic [AW-1:0] tr;
   logic          ovf;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   logic [DW-1:0] mem [0:(1<<AW)-1];
   logic [AW-1:0] wlog_addr [0:63];
   logic [DW-1:0] wlog_data [0:63];
   int            wcount = 0;
   int            n_chk = 0;
   int            n_bad = 0;
   int            cyc = 0;

   always #10 clk = ~clk;

   trail_unit #(
      .ADDR_W(AW), .DATA_W(DW), .TAG_W(8), .VAR_TAG(TAG),
      .TRAIL_TOP(TOP), .TRAIL_FLOOR(FLR)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .bind_valid(bind_valid), .bind_ready(bind_ready),
      .bind_addr(bind_addr), .bind_in_heap(bind_in_heap),
      .mark_b(mark_b), .mark_hb(mark_hb),
      .fail_valid(fail_valid), .fail_tr(fail_tr), .fail_done(fail_done),
      .tr(tr), .ovf(ovf),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   initial begin
      for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_en) begin
         if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wlog_addr[wcount[5:0]] <= mem_addr;
            wlog_data[wcount[5:0]] <= mem_wdata;
            wcount <= wcount + 1;
         end else begin
            mem_rdata <= mem[mem_addr];
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   function automatic logic [31:0] unb(input logic [AW-1:0] a);
      return {TAG, 14'h0, a};
   endfunction

   task automatic do_bind(input string req, input logic [AW-1:0] a, input logic heap, input logic exp_push);
      logic [AW-1:0] tr0;
      int w0;
      @(negedge clk);
      bind_addr = a; bind_in_heap = heap; bind_valid = 1'b1;
      #2;
      tr0 = tr; w0 = wcount;
      chk(req, "bind_ready", {31'h0, bind_ready}, 32'h1);
      chk(req, "mem_we in handshake cycle", {31'h0, mem_we}, {31'h0, exp_push});
      if (exp_push) chk(req, "push slot", {22'h0, mem_addr}, {22'h0, tr0});
      @(posedge clk);
      @(negedge clk);
      bind_valid = 1'b0;
      chk(req, "tr after bind", {22'h0, tr}, {22'h0, exp_push ? tr0 - 1'b1 : tr0});
      chk(req, "write count", wcount - w0, {31'h0, exp_push});
      if (exp_push) chk(req, "trail entry", mem[tr0], {22'h0, a});
   endtask

   task automatic do_fail(input string req, input logic [AW-1:0] saved, input int n);
      int k, w0;
      @(negedge clk);
      fail_valid = 1'b1; fail_tr = saved;
      #2;
      chk("R9", "bind_ready while fail_valid", {31'h0, bind_ready}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      fail_valid = 1'b0;
      w0 = wcount; k = 0;
      while (!fail_done && k < 200) begin
         if (k == 1) chk("R9", "bind_ready during unwind", {31'h0, bind_ready}, 32'h0);
         @(posedge clk);
         @(negedge clk);
         k++;
      end
      chk(req, "edges until fail_done", k, 2*n);
      chk(req, "restoring writes", wcount - w0, n);
      chk(req, "tr after unwind", {22'h0, tr}, {22'h0, saved});
   endtask

   task automatic t_reset();
      #2;
      chk("R1", "tr", {22'h0, tr}, {22'h0, TOP});
      chk("R1", "ovf", {31'h0, ovf}, 32'h0);
      chk("R1", "fail_done", {31'h0, fail_done}, 32'h0);
      chk("R1", "bind_ready", {31'h0, bind_ready}, 32'h1);
      chk("R1", "mem_en", {31'h0, mem_en}, 32'h0);
   endtask

   task automatic t_binds_and_unwind();
      int w0;
      mark_b = 10'h100; mark_hb = 10'h200;
      do_bind("R2", 10'h050, 1'b0, 1'b1);
      do_bind("R4", 10'h100, 1'b0, 1'b0);
      do_bind("R4", 10'h300, 1'b1, 1'b0);
      do_bind("R3", 10'h150, 1'b1, 1'b1);
      do_bind("R3", 10'h150, 1'b0, 1'b0);
      mark_b = 10'h200; mark_hb = 10'h080;
      do_bind("R3", 10'h0F0, 1'b1, 1'b0);
      mark_b = 10'h100; mark_hb = 10'h200;
      w0 = wcount;
      do_fail("R8", TOP, 2);
      chk("R7", "first restore addr", {22'h0, wlog_addr[w0[5:0]]}, 32'h150);
      chk("R7", "second restore addr", {22'h0, wlog_addr[w0[5:0] + 6'd1]}, 32'h050);
      chk("R6", "unbound word 0x150", wlog_data[w0[5:0]], unb(10'h150));
      chk("R6", "mem at 0x050", mem[10'h050], unb(10'h050));
   endtask

   task automatic t_partial();
      int w0;
      do_bind("R2", 10'h010, 1'b0, 1'b1);
      do_bind("R2", 10'h020, 1'b0, 1'b1);
      do_bind("R2", 10'h030, 1'b0, 1'b1);
      w0 = wcount;
      do_fail("R8", 10'h3FE, 2);
      chk("R7", "partial first addr", {22'h0, wlog_addr[w0[5:0]]}, 32'h030);
      chk("R7", "partial second addr", {22'h0, wlog_addr[w0[5:0] + 6'd1]}, 32'h020);
      chk("R6", "older entry untouched", mem[10'h010], 32'h0);
      do_fail("R8", 10'h3FE, 0);
      do_fail("R8", TOP, 1);
      chk("R6", "mem at 0x010", mem[10'h010], unb(10'h010));
   endtask

   task automatic t_overflow();
      for (int i = 1; i <= 8; i++) do_bind("R5", AW'(i), 1'b0, 1'b1);
      chk("R5", "ovf before limit", {31'h0, ovf}, 32'h0);
      do_bind("R5", 10'h009, 1'b0, 1'b0);
      chk("R5", "ovf after dropped push", {31'h0, ovf}, 32'h1);
      chk("R5", "tr at floor-1", {22'h0, tr}, 32'h3F7);
      do_fail("R8", TOP, 8);
      chk("R5", "ovf sticky", {31'h0, ovf}, 32'h1);
      chk("R6", "mem at 0x001", mem[10'h001], unb(10'h001));
   endtask

   task automatic t_priority();
      int w0;
      @(negedge clk);
      w0 = wcount;
      bind_addr = 10'h011; bind_in_heap = 1'b0; bind_valid = 1'b1;
      fail_valid = 1'b1; fail_tr = tr;
      #2;
      chk("R9", "bind_ready with fail_valid", {31'h0, bind_ready}, 32'h0);
      chk("R9", "no push with fail_valid", {31'h0, mem_we}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      fail_valid = 1'b0; bind_valid = 1'b0;
      chk("R8", "immediate done", {31'h0, fail_done}, 32'h1);
      chk("R9", "tr untouched", {22'h0, tr}, {22'h0, TOP});
      chk("R9", "no write", wcount - w0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_binds_and_unwind();
      t_partial();
      t_overflow();
      t_priority();
      repeat (3) @(negedge clk);
      summary();
   end

   initial begin
      wait (cyc > 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
   end
endmodule